// File: doc/BRIEF.md
# Segmented Thermometer Ramp DAC Driver

This block produces the switch-control words for a 12-bit capacitive ramp DAC. The DAC's capacitors are split into a low array and a high array of 6 bits each. A registered binary code is split into a low segment (bits 5:0) and a high segment (bits 11:6). Each segment is expanded into a 63-bit unary word, so every capacitor in that array has its own switch. Because of this unary coding, consecutive codes differ by exactly one switch, except when the low segment rolls over.

The driver has three operating modes:

- **Hold.** The code is pinned at full scale. This is the mode used while the coarse search steps through the references.
- **Sweep.** The code climbs by one per clock. It starts one section below full scale, lowered further by a programmable extension that gives the fine search its redundancy. It raises a one-cycle end flag when it reaches full scale.
- **Test.** The code sits at the midpoint of a selected section. A calibration column can then digitise that known level.

Top module: `ramp_dac_driver`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `code` is 4095, both thermometer words are all ones and `ramp_end` is 0.
- R2: Bit j of `therm_lo` is 1 exactly when `code[5:0]` is greater than j, for j = 0..62.
- R3: Bit j of `therm_hi` is 1 exactly when `code[11:6]` is greater than j, for j = 0..62.
- R4: With `mode` = 0 (hold) or 3 (treated as hold), `code` is 4095 one cycle later and `ramp_end` is 0.
- R5: With `mode` = 1 (sweep) and `start` high, the next `code` is 3584 − `ext_len` (section 7 base minus the extension).
- R6: After a sweep has started, while `mode` stays 1 and `start` is low, `code` increases by exactly 1 per cycle until it reaches 4095.
- R7: Between consecutive sweep codes, exactly one bit of {`therm_hi`,`therm_lo`} changes. The exception is a step onto a code with `code[5:0]` = 0, where 64 bits change.
- R8: `ramp_end` is high for exactly the one cycle in which a sweep's `code` first equals 4095. After that, `code` stays at 4095 until the next start.
- R9: With `mode` = 2 (test), the next `code` is `test_sec`·512 + 256.
- R10: When `start` is high in the same cycle that a sweep would reach full scale, the restart wins: the next `code` is the start value and `ramp_end` stays 0.
- R11: `start` has no effect in hold or test mode: `code` keeps that mode's value.
- R12: When `ext_len` is 3584 or more, the sweep start code saturates at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 hold, 1 sweep, 2 test, 3 hold |
| start | input | 1 | Begins a sweep in sweep mode |
| test_sec | input | 3 | Section whose midpoint is output in test mode |
| ext_len | input | 12 | Downward extension of the sweep start, in LSBs |
| therm_lo | output | 63 | Unary switch word of the low capacitor array |
| therm_hi | output | 63 | Unary switch word of the high capacitor array |
| code | output | 12 | Current binary DAC code |
| ramp_end | output | 1 | One-cycle pulse when a sweep reaches full scale |

## Verification
The sweep's arrival at full scale and a fresh `start` can coincide in one cycle. The bench provokes this by watching for code 4094 and raising `start` in that same cycle. It then judges that the next cycle shows the restart code with `ramp_end` low, and that counting resumes from there. Full sweeps with several extension values are checked at every step: the code, both unary words, the number of bits that changed and the end pulse are all compared against arithmetic expectations.

// File: rtl/ramp_dac_pkg.sv
package ramp_dac_pkg;
  typedef enum logic [1:0] {
    MD_HOLD  = 2'd0,
    MD_SWEEP = 2'd1,
    MD_TEST  = 2'd2,
    MD_SPARE = 2'd3
  } ramp_mode_e;
endpackage

// File: rtl/ramp_therm_enc.sv
module ramp_therm_enc #(
  parameter int SEG_W = 6
) (
  input  logic [SEG_W-1:0]        seg,
  output logic [(2**SEG_W)-2:0]   word
);
  localparam int BITS = (2**SEG_W) - 1;

  for (genvar j = 0; j < BITS; j++) begin : g_bit
    assign word[j] = (seg > SEG_W'(j));
  end
endmodule

// File: rtl/ramp_code_seq.sv
module ramp_code_seq
  import ramp_dac_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int SEC_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              start,
  input  logic [SEC_W-1:0]  test_sec,
  input  logic [CODE_W-1:0] ext_len,
  output logic [CODE_W-1:0] code_nxt,
  output logic [CODE_W-1:0] code,
  output logic              ramp_end
);
  localparam int FINE_W = CODE_W - SEC_W;
  localparam logic [CODE_W-1:0] FULL = '1;
  localparam logic [CODE_W-1:0] TOP_BASE = CODE_W'(((2**SEC_W) - 1) * (2**FINE_W));
  localparam logic [CODE_W-1:0] HALF_SEC = CODE_W'(2**(FINE_W-1));

  ramp_mode_e   md;
  logic         running, run_nxt, end_nxt;
  logic [CODE_W-1:0] start_code, test_code, inc_code;

  assign md         = ramp_mode_e'(mode);
  assign start_code = (ext_len > TOP_BASE) ? '0 : (TOP_BASE - ext_len);
  assign test_code  = {test_sec, {FINE_W{1'b0}}} + HALF_SEC;
  assign inc_code   = code + CODE_W'(1);

  always_comb begin
    code_nxt = code;
    run_nxt  = running;
    end_nxt  = 1'b0;
    unique case (md)
      MD_SWEEP: begin
        if (start) begin
          code_nxt = start_code;
          run_nxt  = 1'b1;
        end else if (running) begin
          code_nxt = inc_code;
          if (inc_code == FULL) begin
            end_nxt = 1'b1;
            run_nxt = 1'b0;
          end
        end
      end
      MD_TEST: begin
        code_nxt = test_code;
        run_nxt  = 1'b0;
      end
      default: begin
        code_nxt = FULL;
        run_nxt  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code     <= FULL;
      running  <= 1'b0;
      ramp_end <= 1'b0;
    end else begin
      code     <= code_nxt;
      running  <= run_nxt;
      ramp_end <= end_nxt;
    end
  end

  // R4: hold mode pins full scale
  p_hold_full_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0) |=> (code == FULL && !ramp_end));

  // R6: an active sweep advances by one
  p_sweep_step_r6: assert property (@(posedge clk) disable iff (rst)
    (running && mode == 2'd1 && !start) |=> (code == $past(code) + CODE_W'(1)));

  // R8: end flag only at full scale and only for one cycle
  p_end_full_r8: assert property (@(posedge clk) disable iff (rst)
    ramp_end |-> (code == FULL));
  p_end_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    ramp_end |=> !ramp_end);

  // R9: test mode lands on a section midpoint
  p_test_mid_r9: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2) |=> (code[FINE_W-1:0] == HALF_SEC[FINE_W-1:0]));
endmodule

// File: rtl/ramp_dac_driver.sv
module ramp_dac_driver #(
  parameter int LSB_W = 6,
  parameter int MSB_W = 6,
  parameter int SEC_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               mode,
  input  logic                     start,
  input  logic [SEC_W-1:0]         test_sec,
  input  logic [LSB_W+MSB_W-1:0]   ext_len,
  output logic [(2**LSB_W)-2:0]    therm_lo,
  output logic [(2**MSB_W)-2:0]    therm_hi,
  output logic [LSB_W+MSB_W-1:0]   code,
  output logic                     ramp_end
);
  localparam int CODE_W = LSB_W + MSB_W;
  localparam int LO_BITS = (2**LSB_W) - 1;
  localparam int HI_BITS = (2**MSB_W) - 1;

  logic [CODE_W-1:0]  code_nxt;
  logic [LO_BITS-1:0] lo_word;
  logic [HI_BITS-1:0] hi_word;

  ramp_code_seq #(.CODE_W(CODE_W), .SEC_W(SEC_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .start    (start),
    .test_sec (test_sec),
    .ext_len  (ext_len),
    .code_nxt (code_nxt),
    .code     (code),
    .ramp_end (ramp_end)
  );

  ramp_therm_enc #(.SEG_W(LSB_W)) u_enc_lo (
    .seg  (code_nxt[LSB_W-1:0]),
    .word (lo_word)
  );

  ramp_therm_enc #(.SEG_W(MSB_W)) u_enc_hi (
    .seg  (code_nxt[CODE_W-1:LSB_W]),
    .word (hi_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      therm_lo <= '1;
      therm_hi <= '1;
    end else begin
      therm_lo <= lo_word;
      therm_hi <= hi_word;
    end
  end

  // R2 / R3: unary words carry as many ones as their segment value
  p_lo_count_r2: assert property (@(posedge clk) disable iff (rst)
    ($countones(therm_lo) == int'(code[LSB_W-1:0])));
  p_hi_count_r3: assert property (@(posedge clk) disable iff (rst)
    ($countones(therm_hi) == int'(code[CODE_W-1:LSB_W])));

  // R7: a single switch moves per unit step away from the low wrap
  p_one_switch_r7: assert property (@(posedge clk) disable iff (rst)
    ((code == $past(code) + CODE_W'(1)) && (code[LSB_W-1:0] != '0))
      |-> ($countones({therm_hi, therm_lo} ^ $past({therm_hi, therm_lo})) == 1));
endmodule

// File: tb/ramp_dac_driver_test.sv
module ramp_dac_driver_test;
  localparam int FULL = 4095;
  localparam int BASE = 3584;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  mode;
  logic        start;
  logic [2:0]  test_sec;
  logic [11:0] ext_len;
  logic [62:0] therm_lo, therm_hi;
  logic [11:0] code;
  logic        ramp_end;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ramp_dac_driver uut (
    .clk(clk), .rst(rst), .mode(mode), .start(start), .test_sec(test_sec),
    .ext_len(ext_len), .therm_lo(therm_lo), .therm_hi(therm_hi),
    .code(code), .ramp_end(ramp_end)
  );

  function automatic logic [62:0] unary(input int v);
    logic [62:0] r;
    for (int j = 0; j < 63; j++) r[j] = (v > j);
    return r;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input int exp_code, input bit exp_end);
    chk({req, " code"}, code, exp_code);
    checks++;
    if (therm_lo !== unary(exp_code % 64)) begin
      errors++;
      $display("FAIL R2 %s therm_lo actual=%h expected=%h", req, therm_lo, unary(exp_code % 64));
    end
    checks++;
    if (therm_hi !== unary(exp_code / 64)) begin
      errors++;
      $display("FAIL R3 %s therm_hi actual=%h expected=%h", req, therm_hi, unary(exp_code / 64));
    end
    chk({req, " ramp_end"}, ramp_end, exp_end);
  endtask

  task automatic full_sweep(input int ext);
    int exp;
    logic [125:0] prev;
    exp = (ext >= BASE) ? 0 : BASE - ext;
    @(negedge clk); mode = 2'd1; start = 1'b1; ext_len = 12'(ext);
    @(negedge clk); start = 1'b0;
    chk_state("R5 R12 start", exp, 1'b0);
    prev = {therm_hi, therm_lo};
    while (exp < FULL) begin
      @(negedge clk);
      exp++;
      chk_state("R6 R8 step", exp, exp == FULL);
      chk("R7 switches", $countones({therm_hi, therm_lo} ^ prev), (exp % 64 == 0) ? 64 : 1);
      prev = {therm_hi, therm_lo};
    end
    @(negedge clk);
    chk_state("R8 after end", FULL, 1'b0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; mode = 2'd0; start = 1'b0; test_sec = '0; ext_len = '0;
    repeat (3) @(negedge clk);
    chk_state("R1 in reset", FULL, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk_state("R1 after reset", FULL, 1'b0);

    // R9 and R11: every section midpoint, start ignored
    for (int m = 0; m < 8; m++) begin
      @(negedge clk); mode = 2'd2; test_sec = 3'(m); start = 1'b0;
      @(negedge clk);
      chk_state("R9 test level", m * 512 + 256, 1'b0);
      start = 1'b1;
      @(negedge clk);
      chk_state("R11 start in test", m * 512 + 256, 1'b0);
      start = 1'b0;
    end

    // R4 and R11: hold, and spare code behaves as hold
    @(negedge clk); mode = 2'd0; start = 1'b1;
    @(negedge clk);
    chk_state("R4 R11 hold", FULL, 1'b0);
    mode = 2'd3;
    @(negedge clk);
    chk_state("R4 spare hold", FULL, 1'b0);
    start = 1'b0;

    full_sweep(0);
    full_sweep(100);
    full_sweep(BASE);
    full_sweep(4000);

    // R10: restart colliding with arrival at full scale
    @(negedge clk); mode = 2'd1; start = 1'b1; ext_len = 12'd0;
    @(negedge clk); start = 1'b0;
    while (code != 12'(FULL - 1)) @(negedge clk);
    start = 1'b1; ext_len = 12'd64;
    @(negedge clk); start = 1'b0;
    chk_state("R10 restart wins", BASE - 64, 1'b0);
    @(negedge clk);
    chk_state("R10 resumes", BASE - 63, 1'b0);

    // R4: leaving sweep mid-ramp returns to full scale and stops counting
    mode = 2'd0;
    @(negedge clk);
    chk_state("R4 abort", FULL, 1'b0);
    mode = 2'd1;
    @(negedge clk);
    chk_state("R6 no resume", FULL, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule